// File: doc/BRIEF.md
# Quad-Channel Chainable Serial Code Loader

This block is the digital front end of a four-channel, 12-bit voltage-output converter. A host shifts a 48-bit frame in on a serial data pin, one bit per rising edge of a serial clock, while an active-low select/load line is held low. When the select line returns high, the whole frame is copied at once into four 12-bit holding registers. The analog stages downstream read these registers as their codes.

The frame carries channel A first, then B, then C, then D, and each field is sent with its most significant bit first. The last shift stage drives a serial output. Several devices can therefore be chained output-to-input on a shared serial clock and select line, and all of them update on the same select rising edge.

The serial pins are not used as clocks. The serial clock, data and select lines are resynchronized onto a faster system clock, and their edges are detected in that domain. A separate active-low clear input zeroes the holding registers without touching the shift register.

Top module: `quad_dac_loader`

## Requirements
- R1: While the system reset `rstN` is low, and once it has been released with no further activity, all four codes read zero and `sdoOut` is low.
- R2: Each rising edge of `sclkIn` seen while `selN` is low shifts the level of `sdiIn` into the shift register. After 48 such shifts, the first 12 bits sent become `codeA` and the following groups become `codeB`, `codeC` and `codeD`. Within each group the first bit sent is the code's bit 11.
- R3: The codes change only when `selN` rises, or under clear. While bits are being shifted they keep their previous values. On a rise of `selN`, all four codes take the shift register contents together.
- R4: While `selN` is high, edges on `sclkIn` move nothing. The shift register contents and `sdoOut` stay as they were.
- R5: A falling edge of `selN` while `sclkIn` is low causes no shift.
- R6: `sdoOut` shows the oldest bit in the shift register. A bit driven on `sdiIn` reappears on `sdoOut` after exactly 48 shifts.
- R7: Pulling `clrN` low sets all four codes to zero at once, without waiting for a clock edge. The shift register is left intact, so a later select pulse with no shifts restores the frame.
- R8: If `selN` rises after some number of shifts other than 48, the codes are loaded from the shift register as it stands. That is the older contents moved up by the number of new bits, with the new bits at the bottom.
- R9: With two devices chained from `sdoOut` to `sdiIn` and sharing the clock and select lines, 96 shifts followed by one select rise give the first 48-bit frame sent to the far device and the second to the near device.
- R10: If `sclkIn` and `selN` rise within the same synchronizer sample, the load takes the contents from before that edge and no shift happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must run several times faster than `sclkIn` |
| rstN | input | 1 | Asynchronous active-low system reset |
| clrN | input | 1 | Asynchronous active-low clear of the four holding registers |
| sclkIn | input | 1 | Serial clock; data are taken on its rising edge |
| sdiIn | input | 1 | Serial data in |
| selN | input | 1 | Active-low select; its rising edge loads the codes |
| sdoOut | output | 1 | Serial data out, the last shift-register stage |
| codeA | output | CHAN_W | Holding register, channel A |
| codeB | output | CHAN_W | Holding register, channel B |
| codeC | output | CHAN_W | Holding register, channel C |
| codeD | output | CHAN_W | Holding register, channel D |

## Verification
A shift strobe and a load strobe can fall in the same system-clock cycle. This happens when the serial clock and the select line rise close enough together that both edges appear in one synchronizer sample. The bench provokes this by raising both lines at the same instant after a known frame. It then judges the result in two ways: the loaded codes must equal that frame unchanged, and a second load with no clocks must return the same values, which shows that no bit slipped in. The same frame is also used to check that clocks during select-high and the select falling edge leave the register alone.

// File: rtl/dac_loader_pkg.sv
package dac_loader_pkg;
  typedef struct packed {
    logic shiftEn;
    logic loadEn;
  } dacStrobes_t;
endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RESET_VAL;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/dac_loader_ctrl.sv
module dac_loader_ctrl
  import dac_loader_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclkS,
  input  logic        selS,
  output dacStrobes_t strobes
);
  logic sclkPrev;
  logic selPrev;

  // Select idles high, so the previous-value register starts high and reset
  // never looks like a load edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      selPrev  <= 1'b1;
    end else begin
      sclkPrev <= sclkS;
      selPrev  <= selS;
    end
  end

  // A clock edge counts only while select is low. A clock edge seen in the
  // same sample as a select rise is dropped, so the load gets clean data.
  always_comb begin
    strobes.shiftEn = sclkS & ~sclkPrev & ~selS;
    strobes.loadEn  = selS & ~selPrev;
  end
endmodule

// File: rtl/dac_loader_dp.sv
module dac_loader_dp
  import dac_loader_pkg::*;
#(
  parameter int CHAN_W = 12,
  parameter int NUM_CH = 4,
  localparam int FRAME_W = CHAN_W * NUM_CH
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clrN,
  input  dacStrobes_t        strobes,
  input  logic               sdiS,
  output logic [FRAME_W-1:0] shiftReg,
  output logic [FRAME_W-1:0] codesFlat
);
  logic holdRstN;
  assign holdRstN = rstN & clrN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shiftReg <= '0;
    else if (strobes.shiftEn) shiftReg <= {shiftReg[FRAME_W-2:0], sdiS};
  end

  // Channel 0 (A) arrives first and so ends up in the top field.
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_hold
    localparam int TOP = FRAME_W - 1 - ch * CHAN_W;
    logic [CHAN_W-1:0] holdReg;
    always_ff @(posedge clk or negedge holdRstN) begin
      if (!holdRstN)           holdReg <= '0;
      else if (strobes.loadEn) holdReg <= shiftReg[TOP -: CHAN_W];
    end
    assign codesFlat[TOP -: CHAN_W] = holdReg;
  end
endmodule

// File: rtl/quad_dac_loader.sv
module quad_dac_loader
  import dac_loader_pkg::*;
#(
  parameter int CHAN_W = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrN,
  input  logic              sclkIn,
  input  logic              sdiIn,
  input  logic              selN,
  output logic              sdoOut,
  output logic [CHAN_W-1:0] codeA,
  output logic [CHAN_W-1:0] codeB,
  output logic [CHAN_W-1:0] codeC,
  output logic [CHAN_W-1:0] codeD
);
  localparam int NUM_CH = 4;
  localparam int FRAME_W = CHAN_W * NUM_CH;
  localparam logic [2:0] SYNC_RST = 3'b100; // {sel, sclk, sdi}

  logic [2:0]         syncOut;
  logic               selS, sclkS, sdiS;
  dacStrobes_t        strobes;
  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] codesFlat;

  dac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rstN(rstN), .din({selN, sclkIn, sdiIn}), .dout(syncOut)
  );
  assign {selS, sclkS, sdiS} = syncOut;

  dac_loader_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclkS(sclkS), .selS(selS), .strobes(strobes)
  );

  dac_loader_dp #(.CHAN_W(CHAN_W), .NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .clrN(clrN), .strobes(strobes), .sdiS(sdiS),
    .shiftReg(shiftReg), .codesFlat(codesFlat)
  );

  assign sdoOut = shiftReg[FRAME_W-1];
  assign codeA = codesFlat[4*CHAN_W-1 -: CHAN_W];
  assign codeB = codesFlat[3*CHAN_W-1 -: CHAN_W];
  assign codeC = codesFlat[2*CHAN_W-1 -: CHAN_W];
  assign codeD = codesFlat[CHAN_W-1 -: CHAN_W];
endmodule

// File: rtl/dac_loader_chk.sv
module dac_loader_chk #(
  parameter int FRAME_W = 48
) (
  input logic               clk,
  input logic               rstN,
  input logic               clrN,
  input logic               shiftEn,
  input logic               loadEn,
  input logic               selS,
  input logic [FRAME_W-1:0] shiftReg,
  input logic [FRAME_W-1:0] codes
);
  p_shift_moves_r2: assert property (@(posedge clk) disable iff (!rstN)
    shiftEn |=> shiftReg[FRAME_W-1:1] == $past(shiftReg[FRAME_W-2:0]));

  p_codes_hold_r3: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    !loadEn |=> $stable(codes));

  p_load_copies_r3: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    loadEn |=> codes == $past(shiftReg));

  p_sel_high_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    selS |=> $stable(shiftReg));

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    !clrN |-> codes == '0);

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({shiftEn, loadEn}));
endmodule

bind quad_dac_loader dac_loader_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rstN(rstN), .clrN(clrN),
  .shiftEn(strobes.shiftEn), .loadEn(strobes.loadEn), .selS(selS),
  .shiftReg(shiftReg), .codes(codesFlat)
);

// File: tb/sim_quad_dac_loader.sv
module sim_quad_dac_loader;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int FW = 4 * CW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clrN = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic selN = 1'b1;
  logic sdo0, sdo1;
  logic [CW-1:0] a0, b0, c0, d0, a1, b1, c1, d1;

  int errors = 0;
  int checks = 0;
  logic [FW-1:0] mdl0 = '0;
  logic [FW-1:0] mdl1 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_dac_loader #(.CHAN_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .clrN(clrN), .sclkIn(sclk), .sdiIn(sdi),
    .selN(selN), .sdoOut(sdo0), .codeA(a0), .codeB(b0), .codeC(c0), .codeD(d0)
  );

  quad_dac_loader #(.CHAN_W(CW)) u1 (
    .clk(clk), .rstN(rstN), .clrN(clrN), .sclkIn(sclk), .sdiIn(sdo0),
    .selN(selN), .sdoOut(sdo1), .codeA(a1), .codeB(b1), .codeC(c1), .codeD(d1)
  );

  task automatic check(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shiftBit(input logic b);
    sdi = b;
    waitClk(3);
    sclk = 1'b1;
    if (selN == 1'b0) begin
      mdl1 = {mdl1[FW-2:0], mdl0[FW-1]};
      mdl0 = {mdl0[FW-2:0], b};
    end
    waitClk(4);
    sclk = 1'b0;
    waitClk(4);
  endtask

  task automatic selLow();
    selN = 1'b0;
    waitClk(5);
  endtask

  task automatic selHigh();
    selN = 1'b1;
    waitClk(6);
  endtask

  task automatic sendFrame(input logic [FW-1:0] w);
    for (int i = FW - 1; i >= 0; i--) shiftBit(w[i]);
  endtask

  function automatic logic [FW-1:0] packCodes(input logic [CW-1:0] a, b, c, d);
    return {a, b, c, d};
  endfunction

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [FW-1:0] frame, saved, partBits;
    logic sdoHold;
    waitClk(3);
    // R1: reset state
    check("R1 codes in reset", packCodes(a0, b0, c0, d0), '0);
    check("R1 sdo in reset", {47'd0, sdo0}, '0);
    rstN = 1'b1;
    waitClk(4);
    check("R1 codes after reset", packCodes(a0, b0, c0, d0), '0);

    // R2/R3: full frames over a sweep of patterns
    for (int p = 0; p < 10; p++) begin
      logic [CW-1:0] ea, eb, ec, ed;
      ea = CW'((p * 1237 + 5) % 4096);
      eb = CW'((p * 2741 + 4095) % 4096);
      ec = (p == 0) ? '1 : CW'(12'hA5A ^ (p * 17));
      ed = (p == 1) ? '0 : CW'((4095 - p * 409) % 4096);
      saved = packCodes(a0, b0, c0, d0);
      selLow();
      sendFrame(packCodes(ea, eb, ec, ed));
      check("R3 codes held while shifting", packCodes(a0, b0, c0, d0), saved);
      selHigh();
      check("R2 channel A field", {36'd0, a0}, {36'd0, ea});
      check("R2 channel B field", {36'd0, b0}, {36'd0, eb});
      check("R2 channel C field", {36'd0, c0}, {36'd0, ec});
      check("R2 channel D field", {36'd0, d0}, {36'd0, ed});
    end

    // R6: sdo replays the previous frame bit by bit
    frame = mdl0;
    selLow();
    for (int i = FW - 1; i >= 0; i--) begin
      check("R6 sdo shows bit sent 48 shifts earlier", {47'd0, sdo0}, {47'd0, frame[i]});
      shiftBit(logic'(i % 3 == 0));
    end
    selHigh();
    saved = mdl0;

    // R4: sclk pulses while select high move nothing
    sdoHold = sdo0;
    shiftBit(1'b1);
    shiftBit(1'b0);
    shiftBit(1'b1);
    check("R4 sdo unchanged under select high", {47'd0, sdo0}, {47'd0, sdoHold});
    // R5: select falls with sclk low, then rises with no clocks
    selLow();
    selHigh();
    check("R5 R4 no shift from select fall or idle clocks", packCodes(a0, b0, c0, d0), saved);

    // R7: asynchronous clear, shift register kept
    clrN = 1'b0;
    #1;
    check("R7 clear is immediate", packCodes(a0, b0, c0, d0), '0);
    waitClk(3);
    check("R7 clear held", packCodes(a0, b0, c0, d0), '0);
    clrN = 1'b1;
    waitClk(2);
    selLow();
    selHigh();
    check("R7 frame restored after clear", packCodes(a0, b0, c0, d0), saved);

    // R8: partial frames of several lengths
    for (int k = 1; k < 60; k += 11) begin
      frame = mdl0;
      partBits = FW'((k * 40503) & 'hFFFF_FFFF);
      selLow();
      for (int i = k - 1; i >= 0; i--) shiftBit(partBits[i % FW]);
      selHigh();
      for (int i = k - 1; i >= 0; i--) frame = {frame[FW-2:0], partBits[i % FW]};
      check("R8 partial frame loads register as it stands", packCodes(a0, b0, c0, d0), frame);
    end

    // R10: sclk and select rise together
    saved = mdl0;
    selLow();
    sdi = ~saved[0];
    waitClk(3);
    sclk = 1'b1;
    selN = 1'b1;
    waitClk(6);
    sclk = 1'b0;
    waitClk(4);
    check("R10 load takes pre-edge contents", packCodes(a0, b0, c0, d0), saved);
    selLow();
    selHigh();
    check("R10 no bit slipped in", packCodes(a0, b0, c0, d0), saved);

    // R9: two-device chain with one shared select
    selLow();
    sendFrame(packCodes(12'h123, 12'h456, 12'h789, 12'hABC));
    sendFrame(packCodes(12'hFED, 12'h0F0, 12'h001, 12'h800));
    selHigh();
    check("R9 far device gets first frame", packCodes(a1, b1, c1, d1),
          packCodes(12'h123, 12'h456, 12'h789, 12'hABC));
    check("R9 near device gets second frame", packCodes(a0, b0, c0, d0),
          packCodes(12'hFED, 12'h0F0, 12'h001, 12'h800));
    check("R9 far device model", packCodes(a1, b1, c1, d1), mdl1);

    finishRun();
  end
endmodule